// File: doc/BRIEF.md
# Programmable LVDS Lane Bit Mapper

This block turns a parallel RGB pixel stream with its sync and data-enable flags into the bit streams of the lanes of a 7:1 serial display link. There is one clock lane and four data lanes by default. The block runs on the fast bit clock and takes one pixel every seven bit clocks. For each pixel it produces one seven-slot word per lane and shifts that word out, slot 6 first and slot 0 last, one slot per clock. The `pix_take` output tells the pixel source in which cycle the inputs are sampled.

Software decides what every slot of every lane carries. Each slot holds its own 5-bit source code. The code can pick any colour bit, one of the sync or enable flags, a software-driven bit, a per-word toggle or a constant. The block therefore covers both common 24-bit lane orderings and any custom ordering, with no fixed table in hardware. A simple write port loads the slot codes, the enable, the polarity inversion controls and the software bit.

The live selector registers are copied into a per-lane shadow at each word boundary. Each output bit is picked from one captured source vector through the shadow code of the slot being sent. A word is therefore never built from a mix of old and new selectors.

Top module: `lvds_lane_mapper`

## Requirements
- R1: After reset, all lane outputs are 0, `pix_take` is 1, the block is disabled, and every slot code is 31, which selects constant zero.
- R2: While enabled, each lane sends the seven slots of its current word on consecutive clocks, in the order slot 6, 5, 4, 3, 2, 1, 0. The bit sent for a slot is the source chosen by that slot's shadow code, taken from the source vector captured at the start of the word.
- R3: Source codes are: 0–7 red bits 0–7, 8–15 green bits 0–7, 16–23 blue bits 0–7, 24 hsync, 25 vsync, 26 data enable, 27 `ce`, 28 software bit, 29 toggle, 30 constant one, 31 constant zero.
- R4: Write address 0 is the control register. In it, bit 0 is enable, bit 1 is the software bit, and bits 2, 3 and 4 invert hsync, vsync and data enable. Address 2k+2 holds slots 0–3 of lane k in fields at bit offsets 0, 5, 10 and 15. Address 2k+3 holds slots 4–6 of lane k at offsets 0, 5 and 10.
- R5: When an inversion bit is set, the matching sync or enable input is inverted before it is captured.
- R6: While disabled, every lane outputs 0, the phase is held at slot 6 and `pix_take` is 1 on every cycle. After enable is written, slot 6 of the first word appears in the next cycle.
- R7: While enabled, `pix_take` is 1 exactly during slot 0 of each word. The inputs present at the following rising edge form the next word.
- R8: A selector write takes effect only at the next word boundary. A write in the middle of a word leaves the word being sent unchanged.
- R9: The toggle source is 0 in the first word after enabling and inverts on each later word.
- R10: With the matching codes loaded, lane 0 sends 1,1,0,0,0,1,1 (slot 6 down to slot 0), and lanes 1–4 send the VESA or JEIDA 24-bit orderings.
- R11: Clearing enable in the middle of a word forces all lanes to 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | DATA_W | Register write data |
| red | input | COLOR_W | Red component of the pixel |
| grn | input | COLOR_W | Green component of the pixel |
| blu | input | COLOR_W | Blue component of the pixel |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| ce | input | 1 | Control-enable flag carried on a lane |
| pix_take | output | 1 | The inputs are sampled at the next rising edge |
| lane_sd | output | N_LANES | Serial bit of each lane |

## Verification
The assertions take for granted that the enable is the only influence on the phase counter. They also assume that the shadow selectors move only on a cycle flagged by `pix_take`, so they say nothing about pixel values. The stimulus keeps every input at a known value from reset and writes only to mapped addresses. It holds the pixel steady across each directed word capture, so that an expected word can be built straight from the pixel fields. Between captures it drives a fresh random pixel every clock, so the phase and shadow properties see writes landing at every slot position.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
   // control register bit positions
   localparam int CTRL_EN   = 0;
   localparam int CTRL_SW   = 1;
   localparam int CTRL_HINV = 2;
   localparam int CTRL_VINV = 3;
   localparam int CTRL_DINV = 4;
   localparam int CTRL_W    = 5;

   // control sources, offset above the colour bits
   typedef enum int {
      SRC_HS = 0,
      SRC_VS = 1,
      SRC_DE = 2,
      SRC_CE = 3,
      SRC_SW = 4
   } ctl_src_e;
   localparam int N_CTL_SRC = 5;
   // constant and toggle codes sit at the top of the code space
   localparam int N_TOP_SRC = 3;
endpackage

// File: rtl/lbm_cfg_regs.sv
module lbm_cfg_regs
   import lbm_pkg::*;
#(
   parameter int N_LANES = 5,
   parameter int SLOTS   = 7,
   parameter int SEL_W   = 5,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [CTRL_W-1:0]              ctrl,
   output logic [N_LANES*SLOTS*SEL_W-1:0] sels
);
   localparam int LO_N  = (SLOTS + 1) / 2;
   localparam int SELS_W = N_LANES * SLOTS * SEL_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         sels <= {SELS_W{1'b1}};
      end else if (we) begin
         if (addr == ADDR_W'(0))
            ctrl <= wdata[CTRL_W-1:0];
         for (int l = 0; l < N_LANES; l++) begin
            for (int s = 0; s < SLOTS; s++) begin
               if (s < LO_N) begin
                  if (addr == ADDR_W'(2 * l + 2))
                     sels[(l*SLOTS+s)*SEL_W +: SEL_W] <= wdata[s*SEL_W +: SEL_W];
               end else begin
                  if (addr == ADDR_W'(2 * l + 3))
                     sels[(l*SLOTS+s)*SEL_W +: SEL_W] <= wdata[(s-LO_N)*SEL_W +: SEL_W];
               end
            end
         end
      end
   end
endmodule

// File: rtl/lbm_src_cap.sv
module lbm_src_cap
   import lbm_pkg::*;
#(
   parameter int COLOR_W = 8,
   parameter int SLOTS   = 7,
   parameter int SEL_W   = 5,
   localparam int SRC_N  = 1 << SEL_W,
   localparam int PH_W   = $clog2(SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CTRL_W-1:0]  ctrl,
   input  logic [COLOR_W-1:0] red,
   input  logic [COLOR_W-1:0] grn,
   input  logic [COLOR_W-1:0] blu,
   input  logic               hsync,
   input  logic               vsync,
   input  logic               de,
   input  logic               ce,
   output logic [PH_W-1:0]    ph,
   output logic               take,
   output logic [SRC_N-1:0]   src_q
);
   localparam int CTL_BASE = 3 * COLOR_W;
   localparam logic [PH_W-1:0] PH_TOP = PH_W'(SLOTS - 1);

   logic             en;
   logic             tog_r;
   logic [SRC_N-1:0] src_n;

   assign en   = ctrl[CTRL_EN];
   assign take = !en || (ph == '0);

   always_comb begin
      src_n = '0;
      src_n[COLOR_W-1:0]           = red;
      src_n[2*COLOR_W-1:COLOR_W]   = grn;
      src_n[3*COLOR_W-1:2*COLOR_W] = blu;
      src_n[CTL_BASE + SRC_HS]     = hsync ^ ctrl[CTRL_HINV];
      src_n[CTL_BASE + SRC_VS]     = vsync ^ ctrl[CTRL_VINV];
      src_n[CTL_BASE + SRC_DE]     = de ^ ctrl[CTRL_DINV];
      src_n[CTL_BASE + SRC_CE]     = ce;
      src_n[CTL_BASE + SRC_SW]     = ctrl[CTRL_SW];
      src_n[SRC_N-3]               = en & tog_r;
      src_n[SRC_N-2]               = 1'b1;
      src_n[SRC_N-1]               = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_TOP;
         tog_r <= 1'b0;
         src_q <= '0;
      end else begin
         if (!en || ph == '0)
            ph <= PH_TOP;
         else
            ph <= ph - PH_W'(1);
         if (take) begin
            src_q <= src_n;
            // first enabled word carries 0: the last disabled capture primes 1
            tog_r <= en ? ~tog_r : 1'b1;
         end
      end
   end
endmodule

// File: rtl/lbm_lane.sv
module lbm_lane #(
   parameter int SLOTS  = 7,
   parameter int SEL_W  = 5,
   localparam int SRC_N = 1 << SEL_W,
   localparam int PH_W  = $clog2(SLOTS),
   localparam int LW    = SLOTS * SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             en,
   input  logic [PH_W-1:0]  ph,
   input  logic [LW-1:0]    sel_live,
   input  logic [SRC_N-1:0] src_q,
   output logic [LW-1:0]    shadow,
   output logic             sd
);
   logic [SEL_W-1:0] cur_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow <= {LW{1'b1}};
      else if (take)
         shadow <= sel_live;
   end

   assign cur_sel = shadow[ph*SEL_W +: SEL_W];
   assign sd      = en & src_q[cur_sel];
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
   import lbm_pkg::*;
#(
   parameter int COLOR_W = 8,
   parameter int N_LANES = 5,
   parameter int SLOTS   = 7,
   parameter int SEL_W   = 5,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0]  cfg_wdata,
   input  logic [COLOR_W-1:0] red,
   input  logic [COLOR_W-1:0] grn,
   input  logic [COLOR_W-1:0] blu,
   input  logic               hsync,
   input  logic               vsync,
   input  logic               de,
   input  logic               ce,
   output logic               pix_take,
   output logic [N_LANES-1:0] lane_sd
);
   localparam int SRC_N  = 1 << SEL_W;
   localparam int PH_W   = $clog2(SLOTS);
   localparam int LW     = SLOTS * SEL_W;
   localparam int SELS_W = N_LANES * LW;
   localparam int LO_N   = (SLOTS + 1) / 2;

   // elaboration-time parameter checks
   if (3 * COLOR_W + N_CTL_SRC + N_TOP_SRC > SRC_N) begin : g_bad_sel
      $error("SEL_W too narrow for the source set");
   end
   if (LO_N * SEL_W > DATA_W) begin : g_bad_data
      $error("DATA_W cannot hold half a lane of selectors");
   end
   if (2 * N_LANES + 2 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end

   logic [CTRL_W-1:0] ctrl;
   logic [SELS_W-1:0] sels;
   logic [SELS_W-1:0] shadow_all;
   logic [PH_W-1:0]   ph;
   logic [SRC_N-1:0]  src_q;
   logic              en;

   assign en = ctrl[CTRL_EN];

   lbm_cfg_regs #(
      .N_LANES(N_LANES), .SLOTS(SLOTS), .SEL_W(SEL_W),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .ctrl(ctrl), .sels(sels)
   );

   lbm_src_cap #(
      .COLOR_W(COLOR_W), .SLOTS(SLOTS), .SEL_W(SEL_W)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
      .red(red), .grn(grn), .blu(blu),
      .hsync(hsync), .vsync(vsync), .de(de), .ce(ce),
      .ph(ph), .take(pix_take), .src_q(src_q)
   );

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      lbm_lane #(
         .SLOTS(SLOTS), .SEL_W(SEL_W)
      ) u_lane (
         .clk(clk), .rst_n(rst_n), .take(pix_take), .en(en), .ph(ph),
         .sel_live(sels[l*LW +: LW]), .src_q(src_q),
         .shadow(shadow_all[l*LW +: LW]), .sd(lane_sd[l])
      );
   end
endmodule

// File: rtl/lbm_chk.sv
module lbm_chk #(
   parameter int N_LANES = 5,
   parameter int SLOTS   = 7,
   parameter int SEL_W   = 5,
   localparam int PH_W   = $clog2(SLOTS),
   localparam int SELS_W = N_LANES * SLOTS * SEL_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic [PH_W-1:0]    ph,
   input logic               pix_take,
   input logic [N_LANES-1:0] lane_sd,
   input logic [SELS_W-1:0]  shadow_all
);
   // R6
   dis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> lane_sd == '0);

   // R6
   dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ph == PH_W'(SLOTS - 1));

   // R2
   ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph != '0) |=> ph == $past(ph) - PH_W'(1));

   // R2
   ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph <= PH_W'(SLOTS - 1));

   // R7
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pix_take) |=> ph == PH_W'(SLOTS - 1));

   // R8
   shd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_take |=> $stable(shadow_all));

   // R11
   en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> lane_sd == '0);
endmodule

bind lvds_lane_mapper lbm_chk #(
   .N_LANES(N_LANES), .SLOTS(SLOTS), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .ph(ph), .pix_take(pix_take),
   .lane_sd(lane_sd), .shadow_all(shadow_all)
);

// File: tb/lvds_lane_mapper_tb.sv
`timescale 1ns/1ps
module lvds_lane_mapper_tb;
   localparam int NL = 5;
   localparam int NS = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [7:0]  red = '0, grn = '0, blu = '0;
   logic        hsync = 1'b0, vsync = 1'b0, de = 1'b0, ce = 1'b0;
   logic        pix_take;
   logic [NL-1:0] lane_sd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   lvds_lane_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .red(red), .grn(grn), .blu(blu),
      .hsync(hsync), .vsync(vsync), .de(de), .ce(ce),
      .pix_take(pix_take), .lane_sd(lane_sd)
   );

   // ---------------- reference model ----------------
   int        m_sel [NL][NS];
   int        m_shd [NL][NS];
   bit [4:0]  m_ctrl;
   bit [31:0] m_src;
   int        m_ph;
   bit        m_tog;
   bit        m_mid;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_sel[l, s]) begin m_sel[l][s] = 31; m_shd[l][s] = 31; end
         m_ctrl = '0; m_src = '0; m_ph = 6; m_tog = 1'b0; m_mid = 1'b0;
      end else begin
         bit en_old;
         en_old = m_ctrl[0];
         if (!en_old || m_ph == 0) begin
            m_src[7:0]   = red;
            m_src[15:8]  = grn;
            m_src[23:16] = blu;
            m_src[24] = hsync ^ m_ctrl[2];
            m_src[25] = vsync ^ m_ctrl[3];
            m_src[26] = de ^ m_ctrl[4];
            m_src[27] = ce;
            m_src[28] = m_ctrl[1];
            m_src[29] = en_old ? m_tog : 1'b0;
            m_src[30] = 1'b1;
            m_src[31] = 1'b0;
            m_tog = en_old ? !m_tog : 1'b1;
            m_shd = m_sel;
            m_mid = 1'b0;
            m_ph = 6;
         end else begin
            m_ph = m_ph - 1;
         end
         if (cfg_we) begin
            if (cfg_addr == 0) m_ctrl = cfg_wdata[4:0];
            else if (cfg_addr >= 2 && cfg_addr < 2 + 2 * NL) begin
               int ln, hi;
               ln = (cfg_addr - 2) / 2;
               hi = (cfg_addr - 2) % 2;
               for (int f = 0; f < 4; f++) begin
                  if (hi == 0) m_sel[ln][f] = int'((cfg_wdata >> (5 * f)) & 32'h1F);
                  else if (f < 3) m_sel[ln][4 + f] = int'((cfg_wdata >> (5 * f)) & 32'h1F);
               end
               if (m_ctrl[0] && en_old && m_ph != 6) m_mid = 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NL-1:0] exp_sd;
         for (int l = 0; l < NL; l++)
            exp_sd[l] = m_ctrl[0] ? m_src[m_shd[l][m_ph]] : 1'b0;
         // R2 lanes follow shadow codes; R6 zero while disabled; R8 mid-word write
         chk(lane_sd == exp_sd, !m_ctrl[0] ? "R6" : (m_mid ? "R8" : "R2"),
             int'(lane_sd), int'(exp_sd));
         // R7 take strobe
         chk(pix_take == (!m_ctrl[0] || m_ph == 0), "R7",
             int'(pix_take), int'(!m_ctrl[0] || m_ph == 0));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int a, input int d);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_lane(input int k, input int c6, c5, c4, c3, c2, c1, c0);
      wr(2 * k + 2, c0 | (c1 << 5) | (c2 << 10) | (c3 << 15));
      wr(2 * k + 3, c4 | (c5 << 5) | (c6 << 10));
   endtask

   task automatic grab7(input int k, output logic [6:0] w);
      for (int i = 0; i < 7; i++) begin
         if (i > 0) @(negedge clk);
         w = {w[5:0], lane_sd[k]};
      end
   endtask

   task automatic get_word(input int k, output logic [6:0] w);
      while (!pix_take) @(negedge clk);
      @(negedge clk);
      grab7(k, w);
   endtask

   task automatic rand_run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         {red, grn, blu} = 24'($urandom);
         {hsync, vsync, de, ce} = 4'($urandom);
      end
   endtask

   localparam int HS = 24, VS = 25, DE = 26, CE = 27, SW = 28, TG = 29, ONE = 30, ZRO = 31;
   function automatic int G(input int i); return 8 + i; endfunction
   function automatic int B(input int i); return 16 + i; endfunction

   initial begin
      #(8 * 200000);
      chk(1'b0, "watchdog", 0, 1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [6:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(lane_sd == '0, "R1", int'(lane_sd), 0);
      chk(pix_take == 1'b1, "R1", int'(pix_take), 1);

      // VESA ordering, R4 field layout
      set_lane(0, ONE, ONE, ZRO, ZRO, ZRO, ONE, ONE);
      set_lane(1, G(0), 5, 4, 3, 2, 1, 0);
      set_lane(2, B(1), B(0), G(5), G(4), G(3), G(2), G(1));
      set_lane(3, DE, VS, HS, B(5), B(4), B(3), B(2));
      set_lane(4, CE, B(7), B(6), G(7), G(6), 7, 6);
      red = 8'hA5; grn = 8'h3C; blu = 8'h96; hsync = 1; vsync = 0; de = 1; ce = 0;
      wr(0, 1);
      get_word(0, w); chk(w == 7'b1100011, "R10", w, 7'b1100011);
      get_word(1, w); chk(w == {grn[0], red[5:0]}, "R10", w, {grn[0], red[5:0]});
      get_word(2, w); chk(w == {blu[1:0], grn[5:1]}, "R3", w, {blu[1:0], grn[5:1]});
      get_word(3, w); chk(w == {de, vsync, hsync, blu[5:2]}, "R3", w, {de, vsync, hsync, blu[5:2]});
      get_word(4, w); chk(w == {ce, blu[7:6], grn[7:6], red[7:6]}, "R4", w, {ce, blu[7:6], grn[7:6], red[7:6]});
      rand_run(200);

      // R5 polarity inversion
      red = 8'h5A; grn = 8'hC3; blu = 8'h69; hsync = 0; vsync = 1; de = 1; ce = 1;
      wr(0, 1 | 4 | 8 | 16);
      get_word(3, w); chk(w == {~de, ~vsync, ~hsync, blu[5:2]}, "R5", w, {~de, ~vsync, ~hsync, blu[5:2]});
      wr(0, 1);
      rand_run(100);

      // JEIDA ordering loaded while running
      set_lane(1, G(2), 7, 6, 5, 4, 3, 2);
      set_lane(2, B(3), B(2), G(7), G(6), G(5), G(4), G(3));
      set_lane(3, DE, VS, HS, B(7), B(6), B(5), B(4));
      set_lane(4, CE, B(1), B(0), G(1), G(0), 1, 0);
      red = 8'h96; grn = 8'h5E; blu = 8'hB1; hsync = 1; vsync = 1; de = 0; ce = 1;
      get_word(1, w); chk(w == {grn[2], red[7:2]}, "R10", w, {grn[2], red[7:2]});
      get_word(2, w); chk(w == {blu[3:2], grn[7:3]}, "R10", w, {blu[3:2], grn[7:3]});
      get_word(3, w); chk(w == {de, vsync, hsync, blu[7:4]}, "R10", w, {de, vsync, hsync, blu[7:4]});
      get_word(4, w); chk(w == {ce, blu[1:0], grn[1:0], red[1:0]}, "R10", w, {ce, blu[1:0], grn[1:0], red[1:0]});

      // R8 selector write in mid-word leaves the current word intact
      fork
         get_word(1, w);
         begin repeat (3) @(negedge clk); wr(4, ONE | (ONE << 5) | (ONE << 10) | (ONE << 15)); end
      join
      chk(w == {grn[2], red[7:2]}, "R8", w, {grn[2], red[7:2]});
      get_word(1, w); chk(w == {grn[2], red[7:6], 4'hF}, "R8", w, {grn[2], red[7:6], 4'hF});

      // R3 software bit through code 28
      set_lane(0, SW, SW, SW, SW, SW, SW, SW);
      wr(0, 3);
      get_word(0, w); chk(w == 7'h7F, "R3", w, 7'h7F);
      wr(0, 1);
      get_word(0, w); chk(w == 7'h00, "R3", w, 7'h00);

      // R11 disable in the middle of a word
      while (!pix_take) @(negedge clk);
      repeat (2) @(negedge clk);
      wr(0, 0);
      chk(lane_sd == '0, "R11", int'(lane_sd), 0);
      chk(pix_take == 1'b1, "R11", int'(pix_take), 1);
      rand_run(20);

      // R9 toggle source, R6 first word right after enable
      set_lane(2, TG, TG, TG, TG, TG, TG, TG);
      wr(0, 1);
      grab7(2, w); chk(w == 7'h00, "R9", w, 7'h00);
      get_word(2, w); chk(w == 7'h7F, "R9", w, 7'h7F);
      get_word(2, w); chk(w == 7'h00, "R9", w, 7'h00);
      rand_run(50);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule